// File: doc/BRIEF.md
# Jump Target and Link Unit

This block resolves the destination of unconditional control transfers in a 32-bit pipeline. It handles three operations: a jump relative to the program counter, the same relative jump that also records a return address, and a jump through an address held in a register operand. The caller supplies the operation code, a 26-bit displacement field, the register operand value and a valid strobe. In the same cycle the block produces the destination address, a taken flag and a write request that stores the return address in register 31.

The block holds its own program counter register. That register is the "current PC" for every computation. It advances to the computed destination on each clock edge where a legal operation is valid. It keeps its value at all other edges, and a synchronous reset clears it to zero. This lets a sequence of jumps be followed through the `pc_o` output. The block has no condition flags and changes none.

Top module: `jump_target_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pc_o` to 0x00000000.
- R2: With `op_i` = 2'b00 (relative jump) and `valid_i` high, `next_pc_o` is `pc_o` plus the 26-bit `disp_i` sign-extended to 32 bits, with bit 0 of `disp_i` treated as zero.
- R3: With `op_i` = 2'b01 (relative jump with link) and `valid_i` high, `next_pc_o` follows the R2 rule. In the same cycle `link_we_o` is 1, `link_idx_o` is 31 and `link_data_o` is `pc_o` + 4, taken from the PC before the update.
- R4: With `op_i` = 2'b10 (indirect jump) and `valid_i` high, `next_pc_o` equals `rs_val_i` with bit 0 forced to 0.
- R5: `link_we_o` is 0 unless `valid_i` is high and `op_i` = 2'b01. Relative and indirect jumps write no register.
- R6: `taken_o` is 1 exactly when `valid_i` is high and `op_i` is one of 2'b00, 2'b01, 2'b10. The code 2'b11 is reserved: it is never taken, it does not move the PC and it does not request a link write.
- R7: `pc_o` takes the value of `next_pc_o` at a rising edge where `taken_o` is 1, and holds its value at every other non-reset edge.
- R8: All address sums wrap modulo 2^32 and have no overflow indication.
- R9: A displacement with bit 25 set is negative and moves the PC backwards.
- R10: When `taken_o` is 0, `next_pc_o` equals `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 00 relative, 01 relative with link, 10 indirect, 11 reserved |
| disp_i | input | 26 | Signed byte displacement for relative jumps |
| rs_val_i | input | 32 | Register operand for the indirect jump |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Destination address (equals `pc_o` when not taken) |
| taken_o | output | 1 | Control transfer happens this cycle |
| link_we_o | output | 1 | Return address write enable |
| link_idx_o | output | 5 | Return address register index (31) |
| link_data_o | output | 32 | Return address, `pc_o` + 4 |

## Verification
The bench drives an odd displacement and an odd register address. A design that skipped the bit 0 mask would land on an odd target and fail both checks. Negative displacements and sums that cross 0xFFFFFFFF catch a zero-extended field or a sum clipped at the top of the address space. A link taken at PC 0xFFFFFFFC must return 0, which catches a link value computed from the updated PC or one that saturates. The reserved code and a dropped valid strobe, sent with link-capable operation codes, catch a PC that moves or a register write that leaks out when no legal operation is present.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

    typedef enum logic [1:0] {
        OP_JREL  = 2'b00,
        OP_JLINK = 2'b01,
        OP_JIND  = 2'b10,
        OP_RSVD  = 2'b11
    } jtu_op_e;

    localparam int unsigned XLEN = 32;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } jtu_state_t;

endpackage

// File: rtl/jtu_target_calc.sv
module jtu_target_calc
    import jtu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 26
) (
    input  jtu_op_e           op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] rs_val,
    output logic [ADDR_W-1:0] target
);

    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] disp_even;
    logic [ADDR_W-1:0] disp_sext;
    logic [ADDR_W-1:0] rel_target;
    logic [ADDR_W-1:0] ind_target;

    always_comb begin
        disp_even  = {disp[DISP_W-1:1], 1'b0};
        disp_sext  = {{EXT_W{disp_even[DISP_W-1]}}, disp_even};
        rel_target = pc + disp_sext;
        ind_target = {rs_val[ADDR_W-1:1], 1'b0};
        target     = (op == OP_JIND) ? ind_target : rel_target;
    end

endmodule

// File: rtl/jtu_link_gen.sv
module jtu_link_gen
    import jtu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned LINK_REG = 31,
    parameter int unsigned STEP     = 4
) (
    input  logic              valid,
    input  jtu_op_e           op,
    input  logic [ADDR_W-1:0] pc,
    output logic              we,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] data
);

    always_comb begin
        we   = valid && (op == OP_JLINK);
        idx  = IDX_W'(LINK_REG);
        data = pc + ADDR_W'(STEP);
    end

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
    import jtu_pkg::*;
#(
    parameter int unsigned DISP_W   = 26,
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned STEP     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid_i,
    input  logic [1:0]                  op_i,
    input  logic [DISP_W-1:0]           disp_i,
    input  logic [XLEN-1:0]             rs_val_i,
    output logic [XLEN-1:0]             pc_o,
    output logic [XLEN-1:0]             next_pc_o,
    output logic                        taken_o,
    output logic                        link_we_o,
    output logic [$clog2(NUM_REGS)-1:0] link_idx_o,
    output logic [XLEN-1:0]             link_data_o
);

    localparam int unsigned IDX_W    = $clog2(NUM_REGS);
    localparam int unsigned LINK_REG = NUM_REGS - 1;

    jtu_op_e    op;
    jtu_state_t st_d, st_q;
    logic [XLEN-1:0] target;
    logic            legal_op;

    assign op = jtu_op_e'(op_i);

    jtu_target_calc #(
        .ADDR_W (XLEN),
        .DISP_W (DISP_W)
    ) i_target (
        .op     (op),
        .pc     (st_q.pc),
        .disp   (disp_i),
        .rs_val (rs_val_i),
        .target (target)
    );

    jtu_link_gen #(
        .ADDR_W   (XLEN),
        .IDX_W    (IDX_W),
        .LINK_REG (LINK_REG),
        .STEP     (STEP)
    ) i_link (
        .valid (valid_i),
        .op    (op),
        .pc    (st_q.pc),
        .we    (link_we_o),
        .idx   (link_idx_o),
        .data  (link_data_o)
    );

    always_comb begin
        legal_op  = (op != OP_RSVD);
        taken_o   = valid_i && legal_op;
        next_pc_o = taken_o ? target : st_q.pc;
        st_d      = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (taken_o) begin
            st_d.pc = target;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (pc_o == '0));

    // R7
    pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |=> (pc_o == $past(next_pc_o)));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !taken_o |=> $stable(pc_o));

    // R5
    link_only_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (taken_o && op_i == 2'b01));

    // R3
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_data_o - pc_o == 32'd4 && link_idx_o == IDX_W'(LINK_REG)));

    // R4
    target_even_chk: assert property (@(posedge clk) disable iff (rst)
        (taken_o && op_i == 2'b10) |-> !next_pc_o[0]);

    // R6
    reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11) |-> (!taken_o && !link_we_o && next_pc_o == pc_o));

endmodule

// File: tb/test_jump_target_unit.sv
`timescale 1ns/1ps
module test_jump_target_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [1:0]  op_i;
    logic [25:0] disp_i;
    logic [31:0] rs_val_i;
    logic [31:0] pc_o, next_pc_o, link_data_o;
    logic        taken_o, link_we_o;
    logic [4:0]  link_idx_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] pc_model;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    jump_target_unit i_jump_target_unit (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (valid_i),
        .op_i        (op_i),
        .disp_i      (disp_i),
        .rs_val_i    (rs_val_i),
        .pc_o        (pc_o),
        .next_pc_o   (next_pc_o),
        .taken_o     (taken_o),
        .link_we_o   (link_we_o),
        .link_idx_o  (link_idx_o),
        .link_data_o (link_data_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rel_ref(input logic [31:0] pc, input logic [25:0] d);
        logic signed [31:0] off;
        off = 32'(signed'(d));
        off[0] = 1'b0;
        return pc + off;
    endfunction

    // Applies one operation, checks the same-cycle outputs, then the PC after the edge.
    task automatic run_op(input string req, input logic v, input logic [1:0] op,
                          input logic [25:0] d, input logic [31:0] rs, input logic [31:0] exp_tgt);
        logic exp_taken, exp_we;
        @(negedge clk);
        valid_i = v; op_i = op; disp_i = d; rs_val_i = rs;
        exp_taken = v && (op != 2'b11);
        exp_we    = v && (op == 2'b01);
        #1;
        chk(req, "taken", 32'(taken_o), 32'(exp_taken));
        chk(req, "next_pc", next_pc_o, exp_taken ? exp_tgt : pc_model);
        chk(req, "link_we", 32'(link_we_o), 32'(exp_we));
        if (exp_we) begin
            chk(req, "link_idx", 32'(link_idx_o), 32'd31);
            chk(req, "link_data", link_data_o, pc_model + 32'd4);
        end
        if (exp_taken) pc_model = exp_tgt;
        @(negedge clk);
        valid_i = 1'b0;
        chk(req, "pc", pc_o, pc_model);
    endtask

    task automatic test_reset();
        rst = 1'b1; valid_i = 1'b0; op_i = 2'b00; disp_i = '0; rs_val_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pc_model = 32'h0;
        chk("R1", "pc after reset", pc_o, 32'h0);
        chk("R6", "idle taken", 32'(taken_o), 32'd0);
        chk("R10", "idle next_pc", next_pc_o, 32'h0);
    endtask

    task automatic test_relative();
        run_op("R2", 1'b1, 2'b00, 26'h0000100, 32'h0, rel_ref(pc_model, 26'h0000100));
        run_op("R2", 1'b1, 2'b00, 26'h0000101, 32'h0, 32'h00000200);
    endtask

    task automatic test_link();
        run_op("R3", 1'b1, 2'b01, 26'h0000040, 32'h0, 32'h00000240);
    endtask

    task automatic test_indirect();
        // R5: indirect jump with an odd address, no link write
        run_op("R4", 1'b1, 2'b10, 26'h0000041, 32'h12345679, 32'h12345678);
    endtask

    task automatic test_negative();
        run_op("R9", 1'b1, 2'b00, 26'h3FFFFF0, 32'h0, 32'h12345668);
        run_op("R9", 1'b1, 2'b01, 26'h2000000, 32'h0, rel_ref(pc_model, 26'h2000000));
    endtask

    task automatic test_reserved_and_hold();
        logic [31:0] held;
        held = pc_model;
        run_op("R6", 1'b1, 2'b11, 26'h0000080, 32'hDEADBEEF, 32'h0);
        chk("R6", "pc after reserved", pc_o, held);
        run_op("R7", 1'b0, 2'b01, 26'h0000080, 32'h0, 32'h0);
        run_op("R5", 1'b0, 2'b10, 26'h0000080, 32'h00001000, 32'h0);
        chk("R10", "pc held", pc_o, held);
    endtask

    task automatic test_wrap();
        run_op("R8", 1'b1, 2'b10, 26'h0, 32'hFFFFFFF0, 32'hFFFFFFF0);
        run_op("R8", 1'b1, 2'b00, 26'h0000020, 32'h0, 32'h00000010);
        run_op("R8", 1'b1, 2'b10, 26'h0, 32'hFFFFFFFC, 32'hFFFFFFFC);
        run_op("R8", 1'b1, 2'b01, 26'h0000008, 32'h0, 32'h00000004);
        run_op("R8", 1'b1, 2'b00, 26'h3FFFFF8, 32'h0, 32'hFFFFFFFC);
    endtask

    initial begin
        test_reset();
        test_relative();
        test_link();
        test_indirect();
        test_negative();
        test_reserved_and_hold();
        test_wrap();
        // R1: reset in mid-sequence clears the PC again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        pc_model = 32'h0;
        chk("R1", "pc after second reset", pc_o, 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule